// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Controller

This block is a cycle-based model of the command and status side of a byte-wide NOR flash memory. A host drives chip-enable, write-enable and output-enable, all active low, together with an address and a data byte. Bus writes feed a command sequencer. The sequencer recognises unlock prefixes and starts byte programs and sector erases on a small internal byte array. Each operation runs for a parameterised number of clock cycles. While an operation runs, reads return a status byte instead of array contents.

Three further features sit on top of this path. An unlock-bypass mode cuts a program down to two writes. An erase can be suspended, so that other sectors can be read or programmed, and then resumed. A per-sector lock input refuses both program and erase on a locked sector. A low-supply input blocks every write. The array is split into equal sectors, and the sector number is the top `SECT_W` bits of the address.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every byte reads 0xFF, `busy` is low and the sequencer is in read mode. A read is a cycle with `ce_n`=0 and `oe_n`=0, and `dout` then shows data during that same cycle. A write is a cycle with `ce_n`=0, `we_n`=0 and `oe_n`=1, taken at the rising clock edge, and each such cycle counts as one write.
- R2: A program is four writes: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the target address and byte. `busy` stays high for exactly `PROG_CYC` cycles after the last write. The stored byte becomes the old byte AND the new byte.
- R3: While `busy` is high, reads of any address return a status byte. Bit 7 is the complement of bit 7 of the byte being programmed, or 0 during an erase. Bit 6 inverts after every read cycle. Bits 5..0 are 0.
- R4: Once an operation completes, reads return array data again and a new command sequence is accepted.
- R5: A sector erase is 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address inside the sector. `busy` stays high for exactly `ERASE_CYC` cycles. Every byte of that sector then reads 0xFF, and every other sector is left unchanged.
- R6: A write of 0xB0 during an erase suspends it and drops `busy`. While suspended, other sectors read as array data and can be programmed with the four-write sequence, after which the block returns to the suspended state. Reads of the erasing sector return a status byte with bit 7 = 0 and a bit 6 that does not change. A program aimed at the erasing sector is refused. A write of 0x30 resumes the erase, which then runs for its remaining cycles.
- R7: When `sect_lock[s]` is 1, a program or erase aimed at sector s is refused. `busy` stays low, the array is unchanged, and the sequencer returns to its idle mode.
- R8: While `low_vdd` is 1, all writes are ignored.
- R9: The sequence 0xAA@0x555, 0x55@0x2AA, 0x20@0x555 enters bypass mode. In bypass mode, a program is 0xA0 (any address) followed by the address and byte. A write of 0x90 followed by 0x00 leaves bypass mode, after which the two-write program no longer works.
- R10: A write that does not match the expected step of a sequence, including 0xF0, returns the sequencer to its idle mode. A stray write in read mode has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| low_vdd | input | 1 | Low-supply indication; blocks writes |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| sect_lock | input | NSECT | Per-sector protection flags |
| dout | output | 8 | Read data or status byte; 0 when not reading |
| busy | output | 1 | High while a program or erase is running |

## Verification
A write is taken at the rising edge that ends its cycle. A read shows its result in the same cycle, decoded from registers that the previous edge updated. The bench therefore drives one bus cycle just after each rising edge and samples `dout` and `busy` at the following falling edge. A scoreboard queue holds the expected byte for each read in issue order. `busy` is counted cycle by cycle after the last write of a sequence and must equal `PROG_CYC` or `ERASE_CYC` exactly. The bench keeps its own copy of the toggle bit and updates it only for reads made while `busy` is high.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [3:0] {
    S_RD, S_U1, S_U2, S_PGM, S_E0, S_E1, S_E2,
    S_PBUSY, S_EBUSY, S_SUSP, S_BYP, S_BYPP, S_BYPX
  } seq_st_t;

  localparam logic [7:0] D_UNLK1  = 8'hAA;
  localparam logic [7:0] D_UNLK2  = 8'h55;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ERPRE  = 8'h80;
  localparam logic [7:0] C_SECT   = 8'h30;
  localparam logic [7:0] C_BYPASS = 8'h20;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_BYPX1  = 8'h90;
  localparam logic [7:0] C_BYPX2  = 8'h00;
endpackage

// File: rtl/flash_timer.sv
module flash_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (run && cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == CW'(1));

  // R2 / R5: a loaded duration is what the counter holds next cycle
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R6: a suspended erase keeps its remaining count
  p_hold_when_paused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 11,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_commit,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              erase_commit,
  input  logic [SECT_W-1:0] erase_sect,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][7:0] words;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(g);
    logic [7:0] cell_q, cell_d;
    logic       cell_en;

    always_comb begin
      cell_en = 1'b0;
      cell_d  = cell_q;
      if (erase_commit && WA[ADDR_W-1 -: SECT_W] == erase_sect) begin
        cell_en = 1'b1;
        cell_d  = 8'hFF;
      end else if (prog_commit && prog_addr == WA) begin
        cell_en = 1'b1;
        cell_d  = cell_q & prog_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= 8'hFF;
      else if (cell_en) cell_q <= cell_d;
    end

    assign words[g] = cell_q;
  end

  assign rd_data = words[rd_addr];

  // R2: programming can only clear bits of the target byte
  p_prog_clears_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_commit && !erase_commit) |=>
      ((words[$past(prog_addr)] & ~$past(words[prog_addr])) == 8'h00));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SECT_W = 3,
  parameter int NSECT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [NSECT-1:0]  prot,
  input  logic              pdone,
  input  logic              edone,
  output seq_st_t           st,
  output logic              susp,
  output logic [SECT_W-1:0] esect,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              start_p,
  output logic              start_e
);
  localparam logic [ADDR_W-1:0] A_1 = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] A_2 = ADDR_W'(12'h2AA);

  seq_st_t           st_q, st_d;
  logic              byp_q, byp_d, susp_q, susp_d;
  logic [SECT_W-1:0] esect_q, wsect;
  logic [ADDR_W-1:0] op_addr_q;
  logic [7:0]        op_data_q;
  seq_st_t           base;
  logic              step1, step2, at_a1, prog_ok;

  always_comb begin
    wsect   = addr[ADDR_W-1 -: SECT_W];
    base    = susp_q ? S_SUSP : (byp_q ? S_BYP : S_RD);
    step1   = (addr == A_1) && (din == D_UNLK1);
    step2   = (addr == A_2) && (din == D_UNLK2);
    at_a1   = (addr == A_1);
    prog_ok = !prot[wsect] && !(susp_q && wsect == esect_q);
  end

  always_comb begin
    st_d    = st_q;
    byp_d   = byp_q;
    susp_d  = susp_q;
    start_p = 1'b0;
    start_e = 1'b0;
    if (wr) begin
      unique case (st_q)
        S_RD, S_SUSP: begin
          if (step1) st_d = S_U1;
          else if (st_q == S_SUSP && din == C_SECT) begin
            st_d   = S_EBUSY;
            susp_d = 1'b0;
          end
        end
        S_U1: st_d = step2 ? S_U2 : base;
        S_U2: begin
          st_d = base;
          if (at_a1 && din == C_PROG) st_d = S_PGM;
          else if (at_a1 && din == C_ERPRE && !susp_q) st_d = S_E0;
          else if (at_a1 && din == C_BYPASS && !susp_q) begin
            st_d  = S_BYP;
            byp_d = 1'b1;
          end
        end
        S_E0: st_d = step1 ? S_E1 : base;
        S_E1: st_d = step2 ? S_E2 : base;
        S_E2: begin
          st_d = base;
          if (din == C_SECT && !prot[wsect]) begin
            st_d    = S_EBUSY;
            start_e = 1'b1;
          end
        end
        S_PGM, S_BYPP: begin
          st_d = base;
          if (prog_ok) begin
            st_d    = S_PBUSY;
            start_p = 1'b1;
          end
        end
        S_BYP: begin
          if (din == C_PROG)       st_d = S_BYPP;
          else if (din == C_BYPX1) st_d = S_BYPX;
        end
        S_BYPX: begin
          st_d = S_BYP;
          if (din == C_BYPX2) begin
            st_d  = S_RD;
            byp_d = 1'b0;
          end
        end
        S_EBUSY: begin
          if (din == C_SUSP) begin
            st_d   = S_SUSP;
            susp_d = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
    if (st_q == S_PBUSY && pdone) st_d = base;
    if (st_q == S_EBUSY && edone) begin
      st_d   = S_RD;
      susp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_RD;
      byp_q  <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      byp_q  <= byp_d;
      susp_q <= susp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr_q <= '0;
      op_data_q <= '0;
    end else if (start_p) begin
      op_addr_q <= addr;
      op_data_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       esect_q <= '0;
    else if (start_e) esect_q <= wsect;
  end

  assign st      = st_q;
  assign susp    = susp_q;
  assign esect   = esect_q;
  assign op_addr = op_addr_q;
  assign op_data = op_data_q;

  // R4: a finished program leaves the busy state on the next edge
  p_prog_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PBUSY && pdone) |=> (st_q != S_PBUSY));

  // R7: a started program never targets a locked sector
  p_lock_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !prot[op_addr_q[ADDR_W-1 -: SECT_W]] || $changed(prot));

  // R6: while suspended the erase sector is frozen
  p_susp_sector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |=> $stable(esect_q));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SECT_W    = 3,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce_n,
  input  logic                     we_n,
  input  logic                     oe_n,
  input  logic                     low_vdd,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [7:0]               din,
  input  logic [(1<<SECT_W)-1:0]   sect_lock,
  output logic [7:0]               dout,
  output logic                     busy
);
  localparam int NSECT = 1 << SECT_W;
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  logic              rs_q1, rs_q2, rst_i;
  seq_st_t           st;
  logic              susp, start_p, start_e, pdone, edone;
  logic [SECT_W-1:0] esect;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data, arr_data, stat;
  logic              rd, wr, show_stat, in_prog, tog_q, tog_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_i = rs_q2;

  assign rd = !ce_n && !oe_n;
  assign wr = !ce_n && !we_n && oe_n && !low_vdd;

  flash_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .NSECT(NSECT)) u_seq (
    .clk(clk), .rst_n(rst_i), .wr(wr), .addr(addr), .din(din),
    .prot(sect_lock), .pdone(pdone), .edone(edone), .st(st), .susp(susp),
    .esect(esect), .op_addr(op_addr), .op_data(op_data),
    .start_p(start_p), .start_e(start_e)
  );

  flash_timer #(.CW(CW)) u_ptim (
    .clk(clk), .rst_n(rst_i), .load(start_p), .load_val(CW'(PROG_CYC)),
    .run(st == S_PBUSY), .done(pdone)
  );

  flash_timer #(.CW(CW)) u_etim (
    .clk(clk), .rst_n(rst_i), .load(start_e), .load_val(CW'(ERASE_CYC)),
    .run(st == S_EBUSY), .done(edone)
  );

  flash_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_arr (
    .clk(clk), .rst_n(rst_i), .prog_commit(pdone), .prog_addr(op_addr),
    .prog_data(op_data), .erase_commit(edone), .erase_sect(esect),
    .rd_addr(addr), .rd_data(arr_data)
  );

  always_comb begin
    in_prog   = (st == S_PBUSY);
    busy      = in_prog || (st == S_EBUSY);
    show_stat = busy || (susp && addr[ADDR_W-1 -: SECT_W] == esect);
    stat      = {in_prog ? ~op_data[7] : 1'b0, tog_q, 6'b0};
    tog_en    = rd && busy;
    dout      = !rd ? 8'h00 : (show_stat ? stat : arr_data);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= ~tog_q;
  end

  // R3: back-to-back busy reads see bit 6 invert
  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (rd && busy && $past(rd && busy)) |-> (dout[6] != $past(dout[6])));

  // R3: low status bits are zero while busy
  p_stat_low_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (rd && busy) |-> (dout[5:0] == 6'b0));

  // R8: no operation can start under a low supply
  p_lowvdd_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (low_vdd && !busy) |=> !busy);
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/100ps
module flash_cmd_ctrl_bench;
  localparam int AW = 11;
  localparam int P  = 8;
  localparam int E  = 64;

  logic clk = 1'b0;
  logic rst_n, ce_n, we_n, oe_n, low_vdd, busy;
  logic [AW-1:0] addr;
  logic [7:0] din, dout;
  logic [7:0] lock;

  int errors = 0;
  int checks = 0;
  bit tog = 1'b0;
  bit done_flag = 1'b0;
  logic [7:0] exp_q[$];
  int         req_q[$];

  always #2.5 clk = ~clk;

  flash_cmd_ctrl u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .low_vdd(low_vdd), .addr(addr), .din(din), .sect_lock(lock),
    .dout(dout), .busy(busy)
  );

  task automatic check(input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares every read cycle against the queue
  always @(negedge clk) begin
    if (!ce_n && !oe_n && rst_n) begin
      if (exp_q.size() == 0) check(0, dout, 'hEE);
      else check(req_q.pop_front(), dout, exp_q.pop_front());
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input int req);
    exp_q.push_back(e);
    req_q.push_back(req);
    @(posedge clk); #1;
    ce_n = 0; we_n = 1; oe_n = 0; addr = a;
  endtask

  task automatic rd_stat(input logic [AW-1:0] a, input bit b7, input int req);
    rd(a, {b7, tog, 6'b0}, req);
    tog = ~tog;
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock(); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase(input logic [AW-1:0] a);
    unlock(); wr(11'h555, 8'h80); unlock(); wr(a, 8'h30);
  endtask

  task automatic wait_idle();
    idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic count_busy(input int exp, input int req);
    int n = 0;
    idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (busy) n++;
      else break;
    end
    check(req, n, exp);
  endtask

  task automatic busy_low(input int req);
    idle();
    @(negedge clk);
    check(req, busy, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce_n = 1; we_n = 1; oe_n = 1; low_vdd = 0;
    addr = '0; din = '0; lock = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: reset state
    busy_low(1);
    rd(11'h010, 8'hFF, 1);
    rd(11'h7FF, 8'hFF, 1);

    // R2: program with exact busy length
    prog(11'h010, 8'h3C);
    count_busy(P, 2);
    rd(11'h010, 8'h3C, 2);

    // R3: status while programming, bit7 = ~0
    prog(11'h011, 8'h5A);
    rd_stat(11'h011, 1'b1, 3);
    rd_stat(11'h400, 1'b1, 3);
    rd_stat(11'h011, 1'b1, 3);
    wait_idle();
    rd(11'h011, 8'h5A, 4);                      // R4

    // R2: program only clears bits (3C & F0)
    prog(11'h010, 8'hF0);
    wait_idle();
    rd(11'h010, 8'h30, 2);
    prog(11'h110, 8'h77);
    wait_idle();

    // R10: aborted sequences and stray writes
    unlock(); wr(11'h555, 8'h12); wr(11'h010, 8'h00);
    idle(); rd(11'h010, 8'h30, 10);
    wr(11'h555, 8'hAA); wr(11'h555, 8'hF0); wr(11'h555, 8'hA0); wr(11'h010, 8'h00);
    busy_low(10);
    rd(11'h010, 8'h30, 10);

    // R7: locked sectors refuse program and erase
    lock = 8'b0000_0100;
    prog(11'h210, 8'h00);
    busy_low(7);
    rd(11'h210, 8'hFF, 7);
    lock = 8'b0000_0010;
    erase(11'h100);
    busy_low(7);
    rd(11'h110, 8'h77, 7);
    lock = '0;

    // R8: low supply blocks writes
    low_vdd = 1;
    prog(11'h040, 8'h00);
    busy_low(8);
    rd(11'h040, 8'hFF, 8);
    low_vdd = 0;

    // R9: bypass two-write program, then exit
    unlock(); wr(11'h555, 8'h20);
    wr(11'h000, 8'hA0); wr(11'h020, 8'h5A);
    count_busy(P, 9);
    rd(11'h020, 8'h5A, 9);
    wr(11'h000, 8'hA0); wr(11'h021, 8'h0F);
    wait_idle();
    rd(11'h021, 8'h0F, 9);
    wr(11'h000, 8'h90); wr(11'h000, 8'h00);
    wr(11'h000, 8'hA0); wr(11'h022, 8'h00);
    busy_low(9);
    rd(11'h022, 8'hFF, 9);

    // R5: erase sector 0, exact busy, neighbour untouched
    erase(11'h005);
    count_busy(E, 5);
    rd(11'h010, 8'hFF, 5);
    rd(11'h021, 8'hFF, 5);
    rd(11'h110, 8'h77, 5);

    // R3: erase status; R6: suspend and resume
    prog(11'h030, 8'h11);
    wait_idle();
    erase(11'h0AB);
    rd_stat(11'h200, 1'b0, 3);
    rd_stat(11'h030, 1'b0, 3);
    wr(11'h000, 8'hB0);
    busy_low(6);
    rd(11'h110, 8'h77, 6);
    rd(11'h030, {1'b0, tog, 6'b0}, 6);
    rd(11'h030, {1'b0, tog, 6'b0}, 6);
    prog(11'h130, 8'h42);
    wait_idle();
    rd(11'h130, 8'h42, 6);
    prog(11'h031, 8'h00);
    busy_low(6);
    rd(11'h031, {1'b0, tog, 6'b0}, 6);
    wr(11'h000, 8'h30);
    idle(); @(negedge clk);
    check(6, busy, 1);
    wait_idle();
    rd(11'h030, 8'hFF, 6);
    rd(11'h031, 8'hFF, 6);
    rd(11'h130, 8'h42, 6);

    // R4: new command accepted after completion
    prog(11'h032, 8'h0F);
    wait_idle();
    rd(11'h032, 8'h0F, 4);
    idle(); idle();

    check(1, exp_q.size(), 0);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule